// File: doc/BRIEF.md
# ADPCM playback decoder

This block turns a stream of 4-bit adaptive delta codes into signed 16-bit audio samples. A phase accumulator is advanced by a programmable rate on each `tick`. Each carry out of the accumulator decodes one nibble. The decoder tracks a running level and an adaptive step size. It averages the newest level with the one before it, scales the result by an 8-bit volume, and interpolates linearly between decode events. Software, outside this block, sets the rate, volume and pointer window, and issues control writes.

Nibbles come from one of two sources. In memory mode they are read from an external sample memory over a pointer window given in nibbles, and the pointer may loop. In feed mode a producer supplies bytes on a valid/ready stream. A byte is accepted on any rising edge where `feed_valid` and `feed_ready` are both high. A producer whose byte is not accepted must hold `feed_data` steady. If no new byte has arrived when one is needed, the decoder reuses the last byte it accepted. The sample side has no back-pressure: `sample_out` is a continuously updated level, and `sample_valid` is a one-cycle strobe on each decode event that the consumer cannot stall.

Top module: `adpcm_play`

## Requirements
- R1: Each cycle with `tick` high, no control write, and playback active, the 17-bit phase register gains `rate`. A result of 65536 or more triggers one decode and keeps only its low 16 bits. `sample_valid` is high for exactly the cycle after the edge of that decode.
- R2: The nibble pointer addresses sample-memory byte `mem_addr` = pointer/2. On an even pointer the byte is fetched and its bits 7:4 are decoded. On an odd pointer bits 3:0 of the byte fetched last are decoded. The pointer then increments.
- R3: The new level is the old level plus trunc(step×M/8), saturated to the range −32768…32767. For code bits [2:0] = k, M = 2k+1, and code bit 3 = 1 makes M negative.
- R4: The new step is trunc(step×S/64), clamped to 127…24576. S is 57 for k = 0…3 and 77, 102, 128, 153 for k = 4, 5, 6, 7.
- R5: A control write with start = 1 clears the level, the averaged target, the increment and the output accumulator. It sets the step to 127 and loads the phase register with 65536 − `rate`. Any control write clears `eos`. It sets the pointer to `start_ptr` in memory mode and to 0 in feed mode.
- R6: On a decode the target becomes trunc((previous level + new level)/2). The accumulator becomes old_target×volume + d×((volume×phase)>>16), where d is the change in target and phase is the low 16 bits after the add. The per-tick increment becomes d×((volume×rate)>>16). Each advancing tick without a decode adds that increment to the accumulator.
- R7: `sample_out` is the low 16 bits of accumulator>>>12. It is 0 while playback is inactive or speaker-off is set.
- R8: Playback is active, and `playing` is high, only when start = 1 and record = 0. While inactive no decode occurs.
- R9: In memory mode a decode that moves the pointer past `stop_ptr` sets `eos`. With repeat set, that decode restarts playback as in R5 from `start_ptr`. Without repeat, the control state is cleared and `playing` falls.
- R10: `feed_ready` reflects a buffer-ready flag, which is 1 after reset and is cleared by an accepted feed byte. In feed mode an even-pointer decode sets the flag again. If a byte is accepted on that same edge, the decode uses it directly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Sample-clock enable; advances the phase |
| ctrl_we | input | 1 | Loads the control fields below |
| ctrl_start | input | 1 | Start bit |
| ctrl_rec | input | 1 | Record bit; blocks playback |
| ctrl_mem | input | 1 | 1: nibbles from memory, 0: from feed stream |
| ctrl_repeat | input | 1 | Loop the memory window |
| ctrl_spk_off | input | 1 | Mute the sample output |
| rate | input | 16 | Phase increment per tick |
| volume | input | 8 | Output scale |
| start_ptr | input | 19 | First nibble of the window |
| stop_ptr | input | 19 | Last nibble of the window |
| mem_addr | output | 18 | Sample-memory byte address |
| mem_rdata | input | 8 | Sample-memory byte, same-cycle |
| feed_valid | input | 1 | Feed byte valid |
| feed_data | input | 8 | Feed byte |
| feed_ready | output | 1 | Decoder wants a feed byte |
| sample_valid | output | 1 | Decode-event strobe |
| sample_out | output | 16 | Signed output sample |
| playing | output | 1 | Playback active |
| eos | output | 1 | End of window reached |

## Verification
The edge that registers a carrying tick or a control write also updates every result of that decode. This covers `sample_valid`, `sample_out`, `eos`, `playing` and `feed_ready`. `mem_addr` follows the pointer combinationally in the same cycle, and `sample_out` depends combinationally on the registered accumulator. The bench drives inputs only between edges. One time unit after each rising edge it steps its model through that edge with the inputs that were present there, and only then compares every output. A result is therefore checked in the very cycle it is due, never one early or late.

// File: rtl/adpcm_pkg.sv
package adpcm_pkg;

  typedef struct packed {
    logic start;
    logic rec;
    logic mem;
    logic rpt;
    logic spk_off;
  } play_ctl_t;

  // Step-size growth factor, in 1/64 units, indexed by code magnitude.
  function automatic logic [7:0] step_factor(input logic [2:0] mag);
    case (mag)
      3'd4:    step_factor = 8'd77;
      3'd5:    step_factor = 8'd102;
      3'd6:    step_factor = 8'd128;
      3'd7:    step_factor = 8'd153;
      default: step_factor = 8'd57;
    endcase
  endfunction

endpackage

// File: rtl/adpcm_phase.sv
module adpcm_phase #(
  parameter int RATE_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              advance,
  input  logic              load,
  input  logic [RATE_W-1:0] rate,
  output logic              carry,
  output logic [RATE_W-1:0] phase_lo
);
  localparam logic [RATE_W:0] FULL = {1'b1, {RATE_W{1'b0}}};

  logic [RATE_W:0] ph_q;
  logic [RATE_W:0] sum;

  always_comb begin
    sum      = ph_q + {1'b0, rate};
    carry    = advance & sum[RATE_W];
    phase_lo = sum[RATE_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q <= '0;
    end else if (load) begin
      ph_q <= FULL - {1'b0, rate};
    end else if (advance) begin
      ph_q <= sum[RATE_W] ? {1'b0, sum[RATE_W-1:0]} : sum;
    end
  end
endmodule

// File: rtl/adpcm_step_math.sv
module adpcm_step_math
  import adpcm_pkg::*;
#(
  parameter int LVL_W    = 16,
  parameter int STEP_MIN = 127,
  parameter int STEP_MAX = 24576
) (
  input  logic [3:0]              code,
  input  logic signed [LVL_W-1:0] level,
  input  logic [LVL_W-1:0]        step,
  output logic signed [LVL_W-1:0] level_n,
  output logic [LVL_W-1:0]        step_n
);
  localparam int PW = LVL_W + 4;
  localparam int SW = LVL_W + 8;
  localparam logic signed [PW:0] LVL_HI = (PW+1)'((2 ** (LVL_W - 1)) - 1);
  localparam logic signed [PW:0] LVL_LO = -(PW+1)'(2 ** (LVL_W - 1));

  logic [PW-1:0]     prod;
  logic signed [PW:0] lvl_x, dlt, total;
  logic [SW-1:0]     grow, grow_sh;

  always_comb begin
    prod  = {4'b0, step} * {{LVL_W{1'b0}}, code[2:0], 1'b1};
    dlt   = $signed({1'b0, prod >> 3});
    lvl_x = level;
    total = code[3] ? (lvl_x - dlt) : (lvl_x + dlt);
    if (total > LVL_HI)      level_n = LVL_HI[LVL_W-1:0];
    else if (total < LVL_LO) level_n = LVL_LO[LVL_W-1:0];
    else                     level_n = total[LVL_W-1:0];

    grow    = {8'b0, step} * {{LVL_W{1'b0}}, step_factor(code[2:0])};
    grow_sh = grow >> 6;
    if (grow_sh > SW'(STEP_MAX))      step_n = LVL_W'(STEP_MAX);
    else if (grow_sh < SW'(STEP_MIN)) step_n = LVL_W'(STEP_MIN);
    else                              step_n = LVL_W'(grow_sh);
  end
endmodule

// File: rtl/adpcm_interp.sv
module adpcm_interp #(
  parameter int LVL_W  = 16,
  parameter int VOL_W  = 8,
  parameter int RATE_W = 16,
  parameter int ACC_W  = 32
) (
  input  logic signed [LVL_W-1:0] old_lvl,
  input  logic signed [LVL_W-1:0] new_lvl,
  input  logic signed [LVL_W-1:0] tgt_q,
  input  logic [VOL_W-1:0]        volume,
  input  logic [RATE_W-1:0]       rate,
  input  logic [RATE_W-1:0]       phase_lo,
  output logic signed [LVL_W-1:0] tgt_n,
  output logic signed [ACC_W-1:0] sstep_n,
  output logic signed [ACC_W-1:0] acc_n
);
  localparam int PRW = VOL_W + RATE_W;

  logic signed [LVL_W:0]   a_x, b_x, pair, pair_adj;
  logic signed [ACC_W-1:0] tn_x, tq_x, dl;
  logic [PRW-1:0]          vr, vp;
  logic [VOL_W-1:0]        vstep, vph;

  always_comb begin
    a_x      = old_lvl;
    b_x      = new_lvl;
    pair     = a_x + b_x;
    pair_adj = pair + $signed({{LVL_W{1'b0}}, pair[LVL_W]});
    tgt_n    = LVL_W'(pair_adj >>> 1);
    tn_x     = tgt_n;
    tq_x     = tgt_q;
    dl       = tn_x - tq_x;
    vr       = {{RATE_W{1'b0}}, volume} * {{VOL_W{1'b0}}, rate};
    vp       = {{RATE_W{1'b0}}, volume} * {{VOL_W{1'b0}}, phase_lo};
    vstep    = VOL_W'(vr >> RATE_W);
    vph      = VOL_W'(vp >> RATE_W);
    sstep_n  = dl * $signed({{(ACC_W-VOL_W){1'b0}}, vstep});
    acc_n    = tq_x * $signed({{(ACC_W-VOL_W){1'b0}}, volume})
             + dl * $signed({{(ACC_W-VOL_W){1'b0}}, vph});
  end
endmodule

// File: rtl/adpcm_play.sv
module adpcm_play
  import adpcm_pkg::*;
#(
  parameter int PTR_W     = 19,
  parameter int RATE_W    = 16,
  parameter int VOL_W     = 8,
  parameter int LVL_W     = 16,
  parameter int ACC_W     = 32,
  parameter int OUT_SHIFT = 12,
  parameter int STEP_MIN  = 127,
  parameter int STEP_MAX  = 24576
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              ctrl_we,
  input  logic              ctrl_start,
  input  logic              ctrl_rec,
  input  logic              ctrl_mem,
  input  logic              ctrl_repeat,
  input  logic              ctrl_spk_off,
  input  logic [RATE_W-1:0] rate,
  input  logic [VOL_W-1:0]  volume,
  input  logic [PTR_W-1:0]  start_ptr,
  input  logic [PTR_W-1:0]  stop_ptr,
  output logic [PTR_W-2:0]  mem_addr,
  input  logic [7:0]        mem_rdata,
  input  logic              feed_valid,
  input  logic [7:0]        feed_data,
  output logic              feed_ready,
  output logic              sample_valid,
  output logic [LVL_W-1:0]  sample_out,
  output logic              playing,
  output logic              eos
);
  play_ctl_t               ctl_q;
  logic [PTR_W-1:0]        ptr_q;
  logic [PTR_W:0]          ptr_inc;
  logic signed [LVL_W-1:0] level_q, level_n, tgt_q, tgt_n;
  logic [LVL_W-1:0]        step_q, step_n;
  logic signed [ACC_W-1:0] sstep_q, sstep_n, acc_q, acc_n;
  logic [3:0]              hold_q, code;
  logic [7:0]              fbyte_q, cpu_byte, fetched;
  logic                    brdy_q, eos_q, valid_q;
  logic                    advance, accept, even, decode, past_end, load_ph;
  logic [RATE_W-1:0]       phase_lo;

  always_comb begin
    playing  = ctl_q.start & ~ctl_q.rec;
    advance  = tick & playing & ~ctrl_we;
    accept   = feed_valid & brdy_q;
    cpu_byte = accept ? feed_data : fbyte_q;
    fetched  = ctl_q.mem ? mem_rdata : cpu_byte;
    even     = ~ptr_q[0];
    code     = even ? fetched[7:4] : hold_q;
    ptr_inc  = {1'b0, ptr_q} + 1'b1;
    past_end = ctl_q.mem & (ptr_inc > {1'b0, stop_ptr});
    load_ph  = (ctrl_we & ctrl_start) | (decode & past_end & ctl_q.rpt);
  end

  adpcm_phase #(.RATE_W(RATE_W)) u_phase (
    .clk(clk), .rst_n(rst_n), .advance(advance), .load(load_ph),
    .rate(rate), .carry(decode), .phase_lo(phase_lo)
  );

  adpcm_step_math #(.LVL_W(LVL_W), .STEP_MIN(STEP_MIN), .STEP_MAX(STEP_MAX)) u_math (
    .code(code), .level(level_q), .step(step_q), .level_n(level_n), .step_n(step_n)
  );

  adpcm_interp #(.LVL_W(LVL_W), .VOL_W(VOL_W), .RATE_W(RATE_W), .ACC_W(ACC_W)) u_interp (
    .old_lvl(level_q), .new_lvl(level_n), .tgt_q(tgt_q), .volume(volume),
    .rate(rate), .phase_lo(phase_lo), .tgt_n(tgt_n), .sstep_n(sstep_n), .acc_n(acc_n)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q   <= '0;
      ptr_q   <= '0;
      level_q <= '0;
      step_q  <= LVL_W'(STEP_MIN);
      tgt_q   <= '0;
      sstep_q <= '0;
      acc_q   <= '0;
      hold_q  <= '0;
      fbyte_q <= '0;
      brdy_q  <= 1'b1;
      eos_q   <= 1'b0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= 1'b0;
      if (accept) fbyte_q <= feed_data;
      if (decode & even & ~ctl_q.mem) brdy_q <= 1'b1;
      else if (accept)                brdy_q <= 1'b0;
      if (ctrl_we) begin
        ctl_q <= '{start: ctrl_start, rec: ctrl_rec, mem: ctrl_mem,
                   rpt: ctrl_repeat, spk_off: ctrl_spk_off};
        eos_q <= 1'b0;
        ptr_q <= ctrl_mem ? start_ptr : '0;
        if (ctrl_start) begin
          level_q <= '0;
          step_q  <= LVL_W'(STEP_MIN);
          tgt_q   <= '0;
          sstep_q <= '0;
          acc_q   <= '0;
        end
      end else if (decode) begin
        valid_q <= 1'b1;
        level_q <= level_n;
        step_q  <= step_n;
        tgt_q   <= tgt_n;
        sstep_q <= sstep_n;
        acc_q   <= acc_n;
        ptr_q   <= ptr_inc[PTR_W-1:0];
        if (even) hold_q <= fetched[3:0];
        if (past_end) begin
          eos_q <= 1'b1;
          if (ctl_q.rpt) begin
            ptr_q   <= start_ptr;
            level_q <= '0;
            step_q  <= LVL_W'(STEP_MIN);
            tgt_q   <= '0;
            sstep_q <= '0;
            acc_q   <= '0;
          end else begin
            ctl_q <= '0;
          end
        end
      end else if (advance) begin
        acc_q <= acc_q + sstep_q;
      end
    end
  end

  assign mem_addr     = ptr_q[PTR_W-1:1];
  assign feed_ready   = brdy_q;
  assign sample_valid = valid_q;
  assign eos          = eos_q;
  assign sample_out   = (playing & ~ctl_q.spk_off) ? LVL_W'(acc_q >>> OUT_SHIFT) : '0;
endmodule

// File: rtl/adpcm_play_chk.sv
module adpcm_play_chk #(
  parameter int LVL_W    = 16,
  parameter int STEP_MIN = 127,
  parameter int STEP_MAX = 24576
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    tick,
  input logic                    ctrl_we,
  input logic                    sample_valid,
  input logic                    playing,
  input logic                    eos,
  input logic                    feed_ready,
  input logic [LVL_W-1:0]        step_q,
  input logic signed [LVL_W-1:0] level_q
);
  AST_DECODE_NEEDS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    sample_valid |-> ($past(tick) && !$past(ctrl_we))); // R1

  AST_DECODE_NEEDS_PLAY: assert property (@(posedge clk) disable iff (!rst_n)
    sample_valid |-> $past(playing)); // R8

  AST_STEP_BOUNDS: assert property (@(posedge clk) disable iff (!rst_n)
    (step_q >= LVL_W'(STEP_MIN)) && (step_q <= LVL_W'(STEP_MAX))); // R4

  AST_LEVEL_MOVES_ON_DECODE: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(level_q) |-> (sample_valid || $past(ctrl_we))); // R3

  AST_STOP_FLAGS_END: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(playing) && !$past(ctrl_we)) |-> eos); // R9

  AST_READY_FROM_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(feed_ready) |-> $past(playing)); // R10
endmodule

bind adpcm_play adpcm_play_chk #(.LVL_W(LVL_W), .STEP_MIN(STEP_MIN), .STEP_MAX(STEP_MAX)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .ctrl_we(ctrl_we),
  .sample_valid(sample_valid), .playing(playing), .eos(eos),
  .feed_ready(feed_ready), .step_q(step_q), .level_q(level_q)
);

// File: tb/adpcm_play_test.sv
`timescale 1ns/1ps
module adpcm_play_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic        ctrl_we = 1'b0, ctrl_start = 1'b0, ctrl_rec = 1'b0, ctrl_mem = 1'b0;
  logic        ctrl_repeat = 1'b0, ctrl_spk_off = 1'b0;
  logic [15:0] rate = 16'h0;
  logic [7:0]  volume = 8'h0;
  logic [18:0] start_ptr = '0, stop_ptr = '0;
  logic [17:0] mem_addr;
  logic [7:0]  mem_rdata;
  logic        feed_valid = 1'b0;
  logic [7:0]  feed_data = 8'h0;
  logic        feed_ready, sample_valid, playing, eos;
  logic [15:0] sample_out;

  int checks = 0, errors = 0;
  bit done = 0;
  bit mem_const_en = 0;
  int mem_const_v = 0;

  // model state
  bit m_start, m_rec, m_mem, m_rpt, m_spk;
  int m_ptr, m_ph, m_lvl, m_step, m_tgt, m_sst, m_acc, m_hold, m_fb;
  bit m_brdy, m_eos, m_valid;

  always #2.5 clk = ~clk;

  function automatic int memfn(int a);
    logic [31:0] h;
    h = a * 32'h9E3779B1;
    return mem_const_en ? mem_const_v : int'(h[18:11]);
  endfunction

  assign mem_rdata = 8'(memfn(int'(mem_addr)));

  adpcm_play uut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .ctrl_we(ctrl_we), .ctrl_start(ctrl_start),
    .ctrl_rec(ctrl_rec), .ctrl_mem(ctrl_mem), .ctrl_repeat(ctrl_repeat),
    .ctrl_spk_off(ctrl_spk_off), .rate(rate), .volume(volume), .start_ptr(start_ptr),
    .stop_ptr(stop_ptr), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
    .feed_valid(feed_valid), .feed_data(feed_data), .feed_ready(feed_ready),
    .sample_valid(sample_valid), .sample_out(sample_out), .playing(playing), .eos(eos)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int f2_of(int mag);
    case (mag)
      4: return 77;
      5: return 102;
      6: return 128;
      7: return 153;
      default: return 57;
    endcase
  endfunction

  task automatic m_restart();
    m_lvl = 0; m_step = 127; m_tgt = 0; m_sst = 0; m_acc = 0;
    m_ph = 65536 - int'(rate);
  endtask

  // Advance the model through one rising edge using the inputs present there.
  task automatic model();
    bit play, adv, accept, dec, fetch_cpu;
    int nib, b, prev, f1, ptgt, dl;
    play = m_start && !m_rec;
    adv = tick && play && !ctrl_we;
    accept = feed_valid && m_brdy;
    dec = 0; fetch_cpu = 0;
    m_valid = 0;
    if (ctrl_we) begin
      m_start = ctrl_start; m_rec = ctrl_rec; m_mem = ctrl_mem;
      m_rpt = ctrl_repeat; m_spk = ctrl_spk_off; m_eos = 0;
      m_ptr = ctrl_mem ? int'(start_ptr) : 0;
      if (ctrl_start) m_restart();
    end else begin
      if (adv) begin
        m_ph += int'(rate);
        if (m_ph > 65535) begin m_ph &= 65535; dec = 1; end
      end
      if (dec) begin
        if (m_ptr % 2 == 0) begin
          b = m_mem ? memfn(m_ptr / 2) : (accept ? int'(feed_data) : m_fb);
          m_hold = b & 15;
          nib = b >> 4;
          fetch_cpu = !m_mem;
        end else nib = m_hold;
        prev = m_lvl;
        f1 = 2 * (nib & 7) + 1;
        if (nib & 8) f1 = -f1;
        m_lvl = prev + (m_step * f1) / 8;
        if (m_lvl > 32767) m_lvl = 32767;
        if (m_lvl < -32768) m_lvl = -32768;
        m_step = (m_step * f2_of(nib & 7)) / 64;
        if (m_step > 24576) m_step = 24576;
        if (m_step < 127) m_step = 127;
        ptgt = m_tgt;
        m_tgt = (prev + m_lvl) / 2;
        dl = m_tgt - ptgt;
        m_sst = dl * ((int'(volume) * int'(rate)) >> 16);
        m_acc = ptgt * int'(volume) + dl * ((int'(volume) * m_ph) >> 16);
        m_valid = 1;
        m_ptr++;
        if (m_mem && m_ptr > int'(stop_ptr)) begin
          m_eos = 1;
          if (m_rpt) begin m_restart(); m_ptr = int'(start_ptr); end
          else begin m_start = 0; m_rec = 0; m_mem = 0; m_rpt = 0; m_spk = 0; end
        end
      end else if (adv) m_acc += m_sst;
    end
    if (accept) m_fb = int'(feed_data);
    if (fetch_cpu) m_brdy = 1;
    else if (accept) m_brdy = 0;
  endtask

  task automatic compare(input string tag);
    int exp_s;
    bit play;
    play = m_start && !m_rec;
    exp_s = (play && !m_spk) ? ((m_acc >>> 12) & 16'hFFFF) : 0;
    chk(int'(sample_out) == exp_s, tag, int'(sample_out), exp_s);
    chk(sample_valid == m_valid, "R1 sample_valid", int'(sample_valid), int'(m_valid));
    chk(playing == play, "R8 playing", int'(playing), int'(play));
    chk(eos == m_eos, "R9 eos", int'(eos), int'(m_eos));
    chk(feed_ready == m_brdy, "R10 feed_ready", int'(feed_ready), int'(m_brdy));
    chk(int'(mem_addr) == (m_ptr / 2) % (1 << 18), "R2 mem_addr", int'(mem_addr), m_ptr / 2);
  endtask

  task automatic cycle(input string tag);
    @(posedge clk);
    #1;
    model();
    compare(tag);
  endtask

  task automatic do_ctrl(input bit s, input bit r, input bit m, input bit p, input bit k);
    ctrl_start = s; ctrl_rec = r; ctrl_mem = m; ctrl_repeat = p; ctrl_spk_off = k;
    ctrl_we = 1;
    cycle("R5 control write");
    ctrl_we = 0;
  endtask

  task automatic run(input int n, input int tick_pct, input int feed_pct, input string tag);
    for (int i = 0; i < n; i++) begin
      tick = ($urandom % 100) < tick_pct;
      feed_valid = ($urandom % 100) < feed_pct;
      feed_data = 8'($urandom);
      cycle(tag);
    end
    tick = 0; feed_valid = 0;
  endtask

  initial begin
    void'($urandom(32'd20240611));
    m_start = 0; m_rec = 0; m_mem = 0; m_rpt = 0; m_spk = 0;
    m_ptr = 0; m_ph = 0; m_lvl = 0; m_step = 127; m_tgt = 0; m_sst = 0; m_acc = 0;
    m_hold = 0; m_fb = 0; m_brdy = 1; m_eos = 0; m_valid = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    #1;
    chk(sample_out == 0, "R7 reset sample_out", int'(sample_out), 0);
    chk(playing == 0, "R8 reset playing", int'(playing), 0);
    chk(feed_ready == 1, "R10 reset feed_ready", int'(feed_ready), 1);
    chk(eos == 0 && sample_valid == 0, "R9 reset eos/valid", int'(eos), 0);

    // R9 memory window without repeat: ends, flags, stops
    rate = 16'h4000; volume = 8'd200; start_ptr = 19'd8; stop_ptr = 19'd15;
    do_ctrl(1, 0, 1, 0, 0);
    chk(sample_out == 0 && playing == 1, "R5 start clears output", int'(sample_out), 0);
    run(60, 100, 0, "R6 window play");
    chk(playing == 0 && eos == 1, "R9 stop after window", int'(playing), 0);

    // R9 repeat keeps looping
    do_ctrl(1, 0, 1, 1, 0);
    run(120, 100, 0, "R6 repeat play");
    chk(playing == 1 && eos == 1, "R9 still looping", int'(playing), 1);

    // R7 speaker off mutes while decoding continues
    do_ctrl(1, 0, 1, 1, 1);
    run(60, 100, 0, "R7 speaker off");
    chk(sample_out == 0 && playing == 1, "R7 muted while playing", int'(sample_out), 0);

    // R8 record bit blocks playback
    do_ctrl(1, 1, 1, 1, 0);
    run(40, 100, 0, "R8 record blocks");
    chk(playing == 0 && sample_out == 0, "R8 inactive with record", int'(playing), 0);

    // R3/R4 positive saturation then step clamps
    mem_const_en = 1; mem_const_v = 8'h77;
    rate = 16'h8000; volume = 8'd255; start_ptr = 19'd0; stop_ptr = 19'd4000;
    do_ctrl(1, 0, 1, 0, 0);
    run(200, 100, 0, "R3 positive saturation");
    mem_const_v = 8'hFF;
    run(200, 100, 0, "R3 negative saturation");
    mem_const_v = 8'h00;
    run(200, 100, 0, "R4 step floor");
    mem_const_v = 8'h88;
    run(100, 100, 0, "R4 negative small");
    mem_const_en = 0;

    // R1 zero rate: one decode from the preload, then none
    rate = 16'h0000;
    do_ctrl(1, 0, 1, 0, 0);
    run(30, 100, 0, "R1 zero rate");
    rate = 16'hFFFF;
    do_ctrl(1, 0, 1, 0, 0);
    run(60, 50, 0, "R1 max rate gapped ticks");

    // R10 feed mode
    rate = 16'h6000; volume = 8'd128;
    do_ctrl(1, 0, 0, 0, 0);
    run(400, 100, 30, "R10 feed mode");
    run(300, 70, 90, "R10 feed eager");

    // random mix
    for (int r = 0; r < 14; r++) begin
      rate = 16'($urandom_range(16'h0100, 16'hFFFF));
      if (r % 4 == 0) rate = 16'($urandom_range(1, 16'h0400));
      volume = 8'($urandom);
      start_ptr = 19'($urandom_range(0, 200));
      stop_ptr = start_ptr + 19'($urandom_range(2, 40));
      do_ctrl(1, 0, ($urandom % 4) != 0, $urandom % 2, ($urandom % 8) == 0);
      run(1500, 85, 50, "R6 random playback");
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(150000 * 5);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired R1 actual=%0d expected=%0d", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule